// File: doc/BRIEF.md
# Interrupt Pin Routing Engine

This block turns interrupt input lines into interrupt messages. It takes up to 24 asynchronous input lines, synchronises them and tracks a request bit for each pin. The pin's routing entry is supplied from a shared table outside the block, in flat configuration vectors. Each entry holds a mask bit, a trigger mode, a vector, a delivery mode, a destination-mode bit and a 16-bit destination. Edge-configured pins latch rising edges. Level-configured pins follow their line and carry a remote-pending bit. That bit is set when a message goes out and is cleared by a matching end-of-interrupt (EOI).

Each cycle, the engine picks the lowest-numbered pin that can be delivered and builds a 32-bit address and a 32-bit data word for it. It places them in a single output register that drains through a valid/ready handshake. EOIs arrive as a one-cycle strobe with a vector. A pin whose remote-pending bit is cleared by an EOI and whose line is still asserted is delivered again.

Top module: `irq_route_engine`

## Requirements
- R1: Input line 0 feeds pin 2, ORed with line 2. Pin 0 has no input, and its request bit stays 0.
- R2: For a level pin (`cfg_level`=1), the request bit follows the synchronised line, set while the line is high and cleared while it is low.
- R3: For an edge pin (`cfg_level`=0), a rising edge sets the request bit only while the pin is unmasked (`cfg_mask`=0). A rising edge on a masked pin is lost and is not delivered after a later unmask.
- R4: A masked pin whose request bit is set stays pending without a message and is delivered once it is unmasked.
- R5: A pin can be delivered when its request bit is set, it is unmasked, and it is either an edge pin or a level pin with remote-pending clear. Among such pins the lowest index goes first, and at most one message is loaded per cycle.
- R6: Delivering an edge pin clears its request bit. Delivering a level pin sets its remote-pending bit, so a line held high yields exactly one message.
- R7: The message address is ADDR_BASE OR destination<<4 OR destination-mode<<2. The message data holds the vector in bits 7:0, the delivery mode in bits 10:8 and the trigger mode in bit 15, with all other bits 0.
- R8: With delivery mode 3'b111, the data vector comes from `ext_vector`, sampled in the load cycle, instead of from the entry.
- R9: An EOI clears remote-pending on every pin that has it set and whose entry vector equals `eoi_vector`. Other pins keep their remote-pending bit. A cleared pin that is unmasked with its request bit still set is delivered again.
- R10: A pin configured as edge has its remote-pending bit cleared at the next clock edge.
- R11: While `msg_valid`=1 and `msg_ready`=0, the message holds with stable address and data, and no further pin is loaded.
- R12: Reset clears all request bits, all remote-pending bits and `msg_valid`. A line change becomes `msg_valid` after the fourth rising clock edge when the output register is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NPINS | Asynchronous interrupt lines |
| cfg_mask | input | NPINS | Per-pin mask |
| cfg_level | input | NPINS | Per-pin trigger mode, 1 = level |
| cfg_dest_mode | input | NPINS | Per-pin destination-mode bit |
| cfg_dlv | input | NPINS*3 | Per-pin delivery mode, pin p at [3p+:3] |
| cfg_vector | input | NPINS*8 | Per-pin vector, pin p at [8p+:8] |
| cfg_dest | input | NPINS*16 | Per-pin destination, pin p at [16p+:16] |
| ext_vector | input | 8 | Vector used for delivery mode 3'b111 |
| eoi_valid | input | 1 | EOI strobe |
| eoi_vector | input | 8 | EOI vector |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Sink accepts message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| irr_o | output | NPINS | Request bits |
| remote_o | output | NPINS | Remote-pending bits |

## Verification
A line change passes two synchroniser stages and then the request register. It reaches `irr_o` after three rising edges and `msg_valid` after four. EOI, configuration and handshake effects reach `remote_o`, `irr_o` and the message register after one edge.

The bench drives every input on the falling edge and samples every output on the falling edge. Its reference model advances on each rising edge from the pre-edge inputs, so each comparison falls half a cycle after the edge that made the result. The directed checks wait a fixed number of falling edges that covers these latencies before they look. The latency check counts exactly three and then four edges.

// File: rtl/irq_route_engine.sv
module irq_route_engine #(
  parameter int NPINS = 24,
  parameter logic [31:0] ADDR_BASE = 32'hFEE0_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   irq_in,
  input  logic [NPINS-1:0]   cfg_mask,
  input  logic [NPINS-1:0]   cfg_level,
  input  logic [NPINS-1:0]   cfg_dest_mode,
  input  logic [NPINS*3-1:0] cfg_dlv,
  input  logic [NPINS*8-1:0] cfg_vector,
  input  logic [NPINS*16-1:0] cfg_dest,
  input  logic [7:0]         ext_vector,
  input  logic               eoi_valid,
  input  logic [7:0]         eoi_vector,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [31:0]        msg_addr,
  output logic [31:0]        msg_data,
  output logic [NPINS-1:0]   irr_o,
  output logic [NPINS-1:0]   remote_o
);
  localparam int IW = $clog2(NPINS);
  localparam logic [2:0] DLV_EXT = 3'b111;

  logic [NPINS-1:0] sync1, sync2, lvl, lvl_q, rise;
  logic [NPINS-1:0] irr, remote, elig, eoi_hit, pick_oh;
  logic [IW-1:0]    sel;
  logic             found, load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      lvl_q <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
      lvl_q <= lvl;
    end
  end

  always_comb begin
    lvl    = sync2;
    lvl[0] = 1'b0;
    lvl[2] = sync2[2] | sync2[0];
  end

  assign rise = lvl & ~lvl_q;
  assign elig = irr & ~cfg_mask & ~(cfg_level & remote);

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_eoi
      assign eoi_hit[p] = eoi_valid && remote[p] && (cfg_vector[p*8 +: 8] == eoi_vector);
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (elig[i]) sel = IW'(i);
  end

  assign found   = |elig;
  assign load    = found && (!msg_valid || msg_ready);
  assign pick_oh = load ? (NPINS'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr    <= '0;
      remote <= '0;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        if (cfg_level[i]) irr[i] <= lvl[i];
        else              irr[i] <= (irr[i] & ~pick_oh[i]) | (rise[i] & ~cfg_mask[i]);
      end
      remote <= ((remote & ~eoi_hit) | pick_oh) & cfg_level;
    end
  end

  logic [7:0]  sel_vec;
  logic [2:0]  sel_dlv;
  logic [15:0] sel_dest;

  assign sel_dlv  = cfg_dlv[sel*3 +: 3];
  assign sel_dest = cfg_dest[sel*16 +: 16];
  assign sel_vec  = (sel_dlv == DLV_EXT) ? ext_vector : cfg_vector[sel*8 +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= ADDR_BASE | (32'(sel_dest) << 4) | (32'(cfg_dest_mode[sel]) << 2);
      msg_data  <= {16'h0, cfg_level[sel], 4'h0, sel_dlv, sel_vec};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  assign irr_o    = irr;
  assign remote_o = remote;
endmodule

// File: rtl/irq_route_engine_chk.sv
module irq_route_engine_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] cfg_mask,
  input logic [NPINS-1:0] cfg_level,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [31:0]      msg_addr,
  input logic [31:0]      msg_data,
  input logic [NPINS-1:0] irr_o,
  input logic [NPINS-1:0] remote_o
);
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R11

  AST_PIN0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irr_o[0]); // R1

  AST_EDGE_NO_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((remote_o & ~$past(cfg_level)) == '0)); // R10

  AST_MASKED_EDGE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr_o & ~$past(irr_o) & ~$past(cfg_level) & $past(cfg_mask)) == '0)); // R3

  AST_ONE_REMOTE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(remote_o & ~$past(remote_o)) <= 1)); // R5

  AST_REMOTE_WITH_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((remote_o & ~$past(remote_o)) == '0) || msg_valid)); // R6
endmodule

bind irq_route_engine irq_route_engine_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/test_irq_route_engine.sv
module test_irq_route_engine;
  localparam int N = 24;
  localparam logic [31:0] BASE = 32'hFEE0_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq = '0, mask = '1, level = '0, dmode = '0;
  logic [N*3-1:0] dlv = '0;
  logic [N*8-1:0] vec;
  logic [N*16-1:0] dest;
  logic [7:0] ext = 8'h00, eoi_vec = 8'h00;
  logic eoi_v = 1'b0, ready = 1'b1;
  logic msg_valid;
  logic [31:0] msg_addr, msg_data;
  logic [N-1:0] irr_o, remote_o;

  int checks = 0, fails = 0, msg_cnt = 0;
  logic [31:0] last_data = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_route_engine #(.NPINS(N), .ADDR_BASE(BASE)) i_irq_route_engine (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .cfg_mask(mask), .cfg_level(level),
    .cfg_dest_mode(dmode), .cfg_dlv(dlv), .cfg_vector(vec), .cfg_dest(dest),
    .ext_vector(ext), .eoi_valid(eoi_v), .eoi_vector(eoi_vec),
    .msg_valid(msg_valid), .msg_ready(ready), .msg_addr(msg_addr), .msg_data(msg_data),
    .irr_o(irr_o), .remote_o(remote_o));

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails < 30) $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_addr(int i);
    return BASE | (32'(dest[i*16 +: 16]) << 4) | (32'(dmode[i]) << 2);
  endfunction

  function automatic logic [31:0] exp_data(int i, logic [7:0] xv);
    logic [7:0] v;
    v = (dlv[i*3 +: 3] == 3'b111) ? xv : vec[i*8 +: 8];
    return {16'h0, level[i], 4'h0, dlv[i*3 +: 3], v};
  endfunction

  function automatic logic [N-1:0] remap(logic [N-1:0] s);
    logic [N-1:0] r;
    r = s; r[0] = 1'b0; r[2] = s[2] | s[0];
    return r;
  endfunction

  // reference model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_lq, m_irr, m_rem;
  logic m_v;
  logic [31:0] m_a, m_d;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_lq = '0; m_irr = '0; m_rem = '0;
      m_v = 1'b0; m_a = '0; m_d = '0;
    end else begin
      logic [N-1:0] l, r, el, oh, eh, ni;
      int s;
      l = remap(m_s2); r = l & ~m_lq;
      el = m_irr & ~mask & ~(level & m_rem);
      s = -1;
      for (int i = N - 1; i >= 0; i--) if (el[i]) s = i;
      oh = '0;
      if (s >= 0 && (!m_v || ready)) begin
        oh[s] = 1'b1; m_v = 1'b1; m_a = exp_addr(s); m_d = exp_data(s, ext);
      end else if (ready) m_v = 1'b0;
      for (int i = 0; i < N; i++) begin
        eh[i] = eoi_v && m_rem[i] && (vec[i*8 +: 8] == eoi_vec);
        ni[i] = level[i] ? l[i] : ((m_irr[i] & ~oh[i]) | (r[i] & ~mask[i]));
      end
      m_rem = ((m_rem & ~eh) | oh) & level;
      m_irr = ni;
      m_lq = l; m_s2 = m_s1; m_s1 = irq;
    end
    if (rst_n && msg_valid && ready) begin
      msg_cnt++;
      last_data = msg_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(msg_valid == m_v, "R5/R11 valid", 64'(msg_valid), 64'(m_v));
      if (m_v) chk({msg_addr, msg_data} == {m_a, m_d}, "R7 message", {msg_addr, msg_data}, {m_a, m_d});
      chk(irr_o == m_irr, "R2/R3/R6 irr", 64'(irr_o), 64'(m_irr));
      chk(remote_o == m_rem, "R6/R9/R10 remote", 64'(remote_o), 64'(m_rem));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int c0;
    for (int i = 0; i < N; i++) begin
      vec[i*8 +: 8] = 8'(8'h20 + i);
      dest[i*16 +: 16] = 16'(i * 16'h0101);
    end
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!msg_valid && irr_o == '0 && remote_o == '0, "R12 reset", {msg_valid, irr_o}, 0);

    // R12 latency, R7 encoding
    mask[5] = 0; vec[5*8 +: 8] = 8'h45; dest[5*16 +: 16] = 16'h1234; dmode[5] = 1; dlv[5*3 +: 3] = 3'b001;
    irq[5] = 1;
    cyc(3);
    chk(!msg_valid, "R12 early", 64'(msg_valid), 0);
    cyc(1);
    chk(msg_valid, "R12 latency", 64'(msg_valid), 1);
    chk(msg_addr == 32'hFEE1_2344 && msg_data == 32'h0000_0145, "R7 fields", {msg_addr, msg_data}, {32'hFEE1_2344, 32'h145});
    irq[5] = 0; cyc(6);

    // R3 masked edge dropped
    c0 = msg_cnt; irq[6] = 1; cyc(6);
    chk(!irr_o[6], "R3 masked rise", 64'(irr_o[6]), 0);
    mask[6] = 0; cyc(6);
    chk(msg_cnt == c0, "R3 no late msg", msg_cnt, c0);
    irq[6] = 0; cyc(4);

    // R2 R6 R9 level behaviour
    level[7] = 1; mask[7] = 0; vec[7*8 +: 8] = 8'h77;
    c0 = msg_cnt; irq[7] = 1; cyc(10);
    chk(msg_cnt == c0 + 1, "R6 one msg", msg_cnt, c0 + 1);
    chk(remote_o[7] && irr_o[7], "R2 level irr/remote", {irr_o[7], remote_o[7]}, 2'b11);
    eoi_vec = 8'h78; eoi_v = 1; cyc(1); eoi_v = 0; cyc(6);
    chk(msg_cnt == c0 + 1 && remote_o[7], "R9 wrong vector", msg_cnt, c0 + 1);
    eoi_vec = 8'h77; eoi_v = 1; cyc(1); eoi_v = 0; cyc(6);
    chk(msg_cnt == c0 + 2, "R9 redeliver", msg_cnt, c0 + 2);
    irq[7] = 0; cyc(5);
    chk(!irr_o[7], "R2 level low", 64'(irr_o[7]), 0);
    eoi_v = 1; cyc(1); eoi_v = 0; cyc(1);
    chk(!remote_o[7], "R9 clear", 64'(remote_o[7]), 0);

    // R10 edge reconfig clears remote
    irq[7] = 1; cyc(8);
    chk(remote_o[7], "R10 setup", 64'(remote_o[7]), 1);
    level[7] = 0; cyc(1);
    chk(!remote_o[7], "R10 cleared", 64'(remote_o[7]), 0);
    irq[7] = 0; mask[7] = 1; cyc(6);

    // R1 line 0 goes to pin 2
    mask[2] = 0; irq[0] = 1; cyc(8);
    chk(last_data[7:0] == 8'h22, "R1 redirect", last_data[7:0], 8'h22);
    irq[0] = 0; cyc(4);

    // R8 external vector
    mask[9] = 0; dlv[9*3 +: 3] = 3'b111; ext = 8'h5A; irq[9] = 1; cyc(8);
    chk(last_data[7:0] == 8'h5A && last_data[10:8] == 3'b111, "R8 ext vector", last_data, 32'h75A);
    irq[9] = 0; dlv[9*3 +: 3] = 3'b000; cyc(4);

    // R4 masked pending
    level[10] = 1; c0 = msg_cnt; irq[10] = 1; cyc(8);
    chk(irr_o[10] && msg_cnt == c0, "R4 pending", {irr_o[10], 32'(msg_cnt)}, {1'b1, 32'(c0)});
    mask[10] = 0; cyc(4);
    chk(msg_cnt == c0 + 1, "R4 unmask", msg_cnt, c0 + 1);
    irq[10] = 0; eoi_vec = vec[10*8 +: 8]; eoi_v = 1; cyc(1); eoi_v = 0; mask[10] = 1; cyc(4);

    // R5 priority, R11 backpressure
    ready = 0; mask[11] = 0; mask[12] = 0; irq[11] = 1; irq[12] = 1; cyc(8);
    chk(msg_valid && msg_data[7:0] == 8'h2B, "R5 lowest first", msg_data[7:0], 8'h2B);
    cyc(3);
    chk(msg_valid && msg_data[7:0] == 8'h2B, "R11 hold", msg_data[7:0], 8'h2B);
    ready = 1; cyc(1);
    chk(msg_valid && msg_data[7:0] == 8'h2C, "R5 next", msg_data[7:0], 8'h2C);
    irq = '0; cyc(6);

    // random phase, checked against the model every cycle
    void'($urandom(32'd4242));
    for (int t = 0; t < 4000; t++) begin
      if (t % 64 == 0) begin
        mask = N'($urandom()) & N'($urandom());
        level = N'($urandom());
        dmode = N'($urandom());
        for (int i = 0; i < N; i++) begin
          dlv[i*3 +: 3] = 3'($urandom_range(7));
          vec[i*8 +: 8] = 8'($urandom_range(16, 40));
        end
      end
      for (int i = 0; i < N; i++) if ($urandom_range(9) == 0) irq[i] = ~irq[i];
      ext = 8'($urandom());
      ready = ($urandom_range(3) != 0);
      eoi_v = ($urandom_range(4) == 0);
      eoi_vec = 8'($urandom_range(16, 40));
      cyc(1);
    end
    eoi_v = 0; ready = 1; cyc(4);
    report();
  end
endmodule